// File: doc/BRIEF.md
# Six-Mode Barrel Shifter

This block moves a 16-bit word left or right by any distance from 0 to 15 in a single pass. A 3-bit selector chooses one of six operations. There are two zero-filling shifts, two arithmetic shifts and two rotations. The two remaining selector codes pass the word through untouched.

The right arithmetic shift fills the upper positions with the sign bit. The left arithmetic shift is deliberately not the same as the logical left shift. It fills the vacated low positions with copies of the word's original bit 0.

The datapath is a cascade of four stages. The stages move the word by 1, 2, 4 and 8 places, and each stage is enabled by one bit of the distance. A parameter adds an output register. With that register present, the result follows the inputs by one clock, and a synchronous reset clears the result.

Top module: `bshift16`

## Requirements
- R1: Mode code 000 (logical left) moves `din` toward bit 15 by `amt` places and fills bits `amt-1..0` with 0.
- R2: Mode code 001 (logical right) moves `din` toward bit 0 by `amt` places and fills the top `amt` bits with 0.
- R3: Mode code 010 (arithmetic left) moves `din` toward bit 15 by `amt` places and fills bits `amt-1..0` with copies of the original `din[0]`.
- R4: Mode code 011 (arithmetic right) moves `din` toward bit 0 by `amt` places and fills the top `amt` bits with copies of the original `din[15]`.
- R5: Mode code 100 (rotate left) sets result bit i to `din[(i - amt) mod 16]`.
- R6: Mode code 101 (rotate right) sets result bit i to `din[(i + amt) mod 16]`.
- R7: Mode codes 110 and 111 return `din` unchanged, whatever the value of `amt`.
- R8: When `amt` is 0, every mode returns `din` unchanged.
- R9: With the output register enabled (the default), `dout` shows the result for the inputs sampled at a rising clock edge. It holds that value until the next rising edge.
- R10: With the output register enabled, `dout` is 0 after any rising edge at which `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| din | input | 16 | Word to be shifted |
| amt | input | 4 | Shift distance, unsigned |
| mode | input | 3 | Operation selector |
| dout | output | 16 | Shifted word |

## Verification
The assertions assume that `din`, `amt` and `mode` are stable across each rising edge and hold known values outside reset. Only the values captured at an edge are related to the following `dout`. The stimulus changes the inputs shortly after the falling edge, never near the rising edge.

The sweep covers all eight selector codes, including the two pass-through codes, and every distance from 0 to 15. Each combination is applied to the patterns 0x0000, 0xFFFF, 0x8000 and 0x0001 and to several random words. This stays inside the legal input space while reaching every fill source.

// File: rtl/bshift16.sv
module bshift16 #(
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] amt,
  input  logic [2:0]           mode,
  output logic [W-1:0]         dout
);
  localparam int AW = $clog2(W);

  localparam logic [2:0] M_SLL = 3'b000;
  localparam logic [2:0] M_SRL = 3'b001;
  localparam logic [2:0] M_SLA = 3'b010;
  localparam logic [2:0] M_SRA = 3'b011;
  localparam logic [2:0] M_ROL = 3'b100;
  localparam logic [2:0] M_ROR = 3'b101;

  logic go_left, rot, pass, fill_l, fill_r;
  logic [W-1:0] stg [AW+1];
  logic [W-1:0] res;

  assign go_left = (mode == M_SLL) || (mode == M_SLA) || (mode == M_ROL);
  assign rot     = (mode == M_ROL) || (mode == M_ROR);
  assign pass    = mode[2] & mode[1];
  assign fill_l  = (mode == M_SLA) & din[0];
  assign fill_r  = (mode == M_SRA) & din[W-1];
  assign stg[0]  = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [W-1:0] lft, rgt;
    assign lft = rot ? {stg[s][W-1-K:0], stg[s][W-1:W-K]}
                     : {stg[s][W-1-K:0], {K{fill_l}}};
    assign rgt = rot ? {stg[s][K-1:0], stg[s][W-1:K]}
                     : {{K{fill_r}}, stg[s][W-1:K]};
    assign stg[s+1] = !amt[s] ? stg[s] : (go_left ? lft : rgt);
  end

  assign res = pass ? din : stg[AW];

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) dout <= '0;
      else     dout <= res;
    end
  end else begin : g_comb
    assign dout = res;
  end
endmodule

module bshift16_chk #(
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [W-1:0]         din,
  input logic [$clog2(W)-1:0] amt,
  input logic [2:0]           mode,
  input logic [W-1:0]         dout
);
  localparam int AW = $clog2(W);
  logic [W-1:0]  d_e;
  logic [AW-1:0] a_e;
  logic [2:0]    m_e;
  logic          v;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk) begin
      d_e <= din;
      a_e <= amt;
      m_e <= mode;
      v   <= !rst;
    end
    // R10
    rst_clear_chk: assert property (@(posedge clk) rst |=> dout == '0);
  end else begin : g_nodly
    assign d_e = din;
    assign a_e = amt;
    assign m_e = mode;
    assign v   = 1'b1;
  end

  // R8
  zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
    (v && a_e == '0) |-> dout == d_e);
  // R7
  pass_code_chk: assert property (@(posedge clk) disable iff (rst)
    (v && m_e[2:1] == 2'b11) |-> dout == d_e);
  // R5
  rol_count_chk: assert property (@(posedge clk) disable iff (rst)
    (v && m_e == 3'b100) |-> $countones(dout) == $countones(d_e));
  // R6
  ror_count_chk: assert property (@(posedge clk) disable iff (rst)
    (v && m_e == 3'b101) |-> $countones(dout) == $countones(d_e));
  // R4
  sra_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (v && m_e == 3'b011) |-> dout[W-1] == d_e[W-1]);
  // R3
  sla_low_chk: assert property (@(posedge clk) disable iff (rst)
    (v && m_e == 3'b010) |-> dout[0] == d_e[0]);
  // R1
  sll_low_chk: assert property (@(posedge clk) disable iff (rst)
    (v && m_e == 3'b000 && a_e != '0) |-> !dout[0]);
  // R2
  srl_high_chk: assert property (@(posedge clk) disable iff (rst)
    (v && m_e == 3'b001 && a_e != '0) |-> !dout[W-1]);
endmodule

bind bshift16 bshift16_chk #(.W(W), .OUT_REG(OUT_REG)) i_chk (.*);

// File: tb/test_bshift16.sv
module test_bshift16;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  din = '0;
  logic [3:0]    amt = '0;
  logic [2:0]    mode = '0;
  logic [W-1:0]  dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [W-1:0] exp; string req; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  bshift16 #(.W(W), .OUT_REG(1'b1)) i_bshift16 (
    .clk(clk), .rst(rst), .din(din), .amt(amt), .mode(mode), .dout(dout));

  function automatic logic [W-1:0] model(logic [W-1:0] d, int a, logic [2:0] m);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case (m)
        3'b000: r[i] = (i - a >= 0) ? d[i-a] : 1'b0;
        3'b001: r[i] = (i + a < W)  ? d[i+a] : 1'b0;
        3'b010: r[i] = (i - a >= 0) ? d[i-a] : d[0];
        3'b011: r[i] = (i + a < W)  ? d[i+a] : d[W-1];
        3'b100: r[i] = d[(i - a + W) % W];
        3'b101: r[i] = d[(i + a) % W];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(int a, logic [2:0] m);
    if (m[2:1] == 2'b11) return "R7";
    if (a == 0) return "R8";
    case (m)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(logic [W-1:0] act, logic [W-1:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] d, int a, logic [2:0] m);
    item_t it;
    @(negedge clk);
    #1;
    din  = d;
    amt  = a[3:0];
    mode = m;
    it.exp = model(d, a, m);
    it.req = req_of(a, m);
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        check(dout, it.exp, it.req);
      end
    end
  end

  initial begin : stim
    logic [W-1:0] pats [7];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8000; pats[3] = 16'h0001;
    for (int i = 4; i < 7; i++) pats[i] = W'($urandom);

    din = 16'hBEEF; amt = 4'd3; mode = 3'b100;
    repeat (3) @(negedge clk);
    check(dout, '0, "R10");
    @(negedge clk);
    #1 rst = 1'b0;

    drive(16'h1234, 0, 3'b000);
    @(negedge clk);
    #1 din = 16'hF0F0; amt = 4'd4; mode = 3'b001;
    #1 check(dout, 16'h1234, "R9");
    q.push_back('{exp: 16'h0F0F, req: "R9"});

    drive(16'hA5A5, 5, 3'b100);
    @(negedge clk);
    #1 rst = 1'b1;
    @(negedge clk);
    check(dout, '0, "R10");
    #1 rst = 1'b0;

    for (int m = 0; m < 8; m++)
      for (int a = 0; a < 16; a++)
        for (int p = 0; p < 7; p++)
          drive(pats[p], a, 3'(m));

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin : finish_blk
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule